// File: doc/BRIEF.md
# Flagged Integer Arithmetic and Logic Unit

A purely combinational datapath unit for a 32-bit processor execute stage. Two operands and a five-bit operation code go in; a result word and four condition flags (negative, overflow, carry, zero) come out in the same cycle. Inside, one adder/subtractor, one bidirectional barrel shifter and one bitwise logic unit run in parallel. The code picks which of them drives the result and whether the adder subtracts.

The shifter takes its distance from operand A and its data from operand B. Set-on-less-than results come from the subtractor's flags, so signed and unsigned compares need no comparator of their own. The flags always describe the adder, whatever unit is selected, except zero, which describes the final result. A control decoder drives the code; the result feeds register write-back, and the flags feed branch resolution.

Top module: `alu_core`

## Requirements
- R1: The operation code `fn` is split as fn[4] = subtract, fn[3:2] = selector, fn[1] = shift-enable, fn[0] = math-enable. Code 5'b00001 (math, no shift, add) gives A+B modulo 2^32.
- R2: Code 5'b10001 gives A-B modulo 2^32.
- R3: With shift-enable=0 and math-enable=0, selector 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives NOR of A and B. fn[4] has no effect on the result.
- R4: With shift-enable=1 and math-enable=0, the unit shifts B by the distance A[4:0]. Selector 00 or 01 gives a logical left shift, 10 a logical right shift and 11 an arithmetic right shift. A[31:5] has no effect.
- R5: With shift-enable=1, math-enable=1 and selector bit 0 = 0, the result is 32'd1 when A < B as signed two's-complement values and 32'd0 otherwise, whatever fn[4] is.
- R6: With shift-enable=1, math-enable=1 and selector bit 0 = 1, the result is 32'd1 when A < B as unsigned values and 32'd0 otherwise, whatever fn[4] is.
- R7: `flag_z` is 1 exactly when the selected 32-bit result is zero, in every mode.
- R8: In add and subtract modes, `flag_n` is bit 31 of the result and `flag_v` is signed overflow. `flag_c` is the adder's carry-out. Subtraction is done as A + ~B + 1, so on subtract `flag_c` is 1 exactly when A >= B unsigned.
- R9: A shift distance of 0 returns B unchanged in every shift mode. An arithmetic right shift by 31 fills the whole word with B[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | Operand A; also the shift distance (low 5 bits) |
| b | input | 32 | Operand B; the value that is shifted |
| fn | input | 5 | Operation code {subtract, selector[1:0], shift-enable, math-enable} |
| result | output | 32 | Selected result word |
| flag_n | output | 1 | Negative: MSB of the adder output |
| flag_v | output | 1 | Signed overflow of the adder |
| flag_c | output | 1 | Carry-out of the adder |
| flag_z | output | 1 | Result is all zeros |

## Verification
The hardest case to reach is a compare whose answer depends on the overflow term. In that case the signed order and the sign of the raw difference disagree, as in 0x80000000 against 1 or 0x7FFFFFFF against 0xFFFFFFFF. The stimulus places operands on both sides of the sign boundary and runs each pair through both compare codes, with fn[4] both low and high. This shows that the subtract is forced and that N XOR V and the carry-out are each read the right way round. Shift corners are reached by setting bits of A above bit 4 and by using distances of 0 and 31.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef struct packed {
      logic       sub;
      logic [1:0] sel;
      logic       shift;
      logic       math;
   } alu_fn_t;

   // Unit chosen by {shift, math}
   typedef enum logic [1:0] {
      UNIT_LOGIC = 2'b00,
      UNIT_ADD   = 2'b01,
      UNIT_SHIFT = 2'b10,
      UNIT_CMP   = 2'b11
   } alu_unit_e;

   typedef enum logic [1:0] {
      LOP_AND = 2'b00,
      LOP_OR  = 2'b01,
      LOP_XOR = 2'b10,
      LOP_NOR = 2'b11
   } logic_op_e;

   function automatic alu_unit_e unit_of(input alu_fn_t f);
      return alu_unit_e'({f.shift, f.math});
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH       = 32,
   parameter bit RIPPLE_IMPL = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             neg,
   output logic             ovf,
   output logic             cout
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{sub}};

   generate
      if (RIPPLE_IMPL) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = cy[WIDTH];
      end else begin : g_native
         logic [WIDTH:0] wide;
         assign wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   assign neg = sum[MSB];
   assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int WIDTH        = 32,
   parameter bit BARREL_IMPL  = 1'b1,
   localparam int SHW         = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val,
   input  logic [SHW-1:0]   amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] res
);
   generate
      if (BARREL_IMPL) begin : g_barrel
         logic [WIDTH-1:0] val_rev;
         logic [WIDTH-1:0] out_rev;
         logic [WIDTH-1:0] stage [SHW+1];
         logic             fill;

         for (genvar i = 0; i < WIDTH; i++) begin : g_rev
            assign val_rev[i] = val[WIDTH-1-i];
            assign out_rev[i] = stage[SHW][WIDTH-1-i];
         end

         // Left shifts run through the right-shift network on a mirrored word
         assign stage[0] = left ? val_rev : val;
         assign fill     = arith & ~left & val[WIDTH-1];

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][WIDTH-1:D]} : stage[s];
         end

         assign res = left ? out_rev : stage[SHW];
      end else begin : g_behav
         always_comb begin
            if (left)       res = val << amt;
            else if (arith) res = $unsigned($signed(val) >>> amt);
            else            res = val >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (logic_op_e'(sel))
         LOP_AND: res = a & b;
         LOP_OR:  res = a | b;
         LOP_XOR: res = a ^ b;
         LOP_NOR: res = ~(a | b);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH         = 32,
   parameter bit RIPPLE_ADDER  = 1'b0,
   parameter bit BARREL_SHIFT  = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [4:0]       fn,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_v,
   output logic             flag_c,
   output logic             flag_z
);
   localparam int SHW = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("alu_core: WIDTH must be a power of two and at least 2");
      end
   endgenerate

   alu_fn_t          code;
   alu_unit_e        unit;
   logic             do_sub;
   logic [WIDTH-1:0] sum, shifted, logic_res;
   logic             lt_signed, lt_unsigned;

   assign code   = alu_fn_t'(fn);
   assign unit   = unit_of(code);
   assign do_sub = code.sub | (unit == UNIT_CMP);

   alu_addsub #(.WIDTH(WIDTH), .RIPPLE_IMPL(RIPPLE_ADDER)) u_addsub (
      .a    (a),
      .b    (b),
      .sub  (do_sub),
      .sum  (sum),
      .neg  (flag_n),
      .ovf  (flag_v),
      .cout (flag_c)
   );

   alu_shifter #(.WIDTH(WIDTH), .BARREL_IMPL(BARREL_SHIFT)) u_shift (
      .val   (b),
      .amt   (a[SHW-1:0]),
      .left  (~code.sel[1]),
      .arith (code.sel[1] & code.sel[0]),
      .res   (shifted)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (a),
      .b   (b),
      .sel (code.sel),
      .res (logic_res)
   );

   assign lt_signed   = flag_n ^ flag_v;
   assign lt_unsigned = ~flag_c;

   always_comb begin
      unique case (unit)
         UNIT_ADD:   result = sum;
         UNIT_SHIFT: result = shifted;
         UNIT_CMP:   result = {{(WIDTH-1){1'b0}}, code.sel[0] ? lt_unsigned : lt_signed};
         default:    result = logic_res;
      endcase
   end

   assign flag_z = ~|result;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [4:0]       fn,
   input logic [WIDTH-1:0] result,
   input logic             flag_n,
   input logic             flag_v,
   input logic             flag_c,
   input logic             flag_z
);
   always_comb begin
      if (fn == 5'b00001) begin
         assert_add_inverse_R1: assert (result - b == a)
            else $error("add result inconsistent");
         assert_add_carry_R8: assert (flag_c == (result < a))
            else $error("add carry wrong");
      end
      if (fn == 5'b10001) begin
         assert_sub_inverse_R2: assert (result + b == a)
            else $error("sub result inconsistent");
         assert_sub_zero_R7: assert (flag_z == (a == b))
            else $error("sub zero flag wrong");
      end
      if (fn[1:0] == 2'b11 && fn[2] == 1'b0) begin
         assert_signed_cmp_R5: assert (result == {{(WIDTH-1){1'b0}}, $signed(a) < $signed(b)})
            else $error("signed compare wrong");
      end
      if (fn[1:0] == 2'b11 && fn[2] == 1'b1) begin
         assert_unsigned_cmp_R6: assert (result == {{(WIDTH-1){1'b0}}, a < b})
            else $error("unsigned compare wrong");
      end
   end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
   .a      (a),
   .b      (b),
   .fn     (fn),
   .result (result),
   .flag_n (flag_n),
   .flag_v (flag_v),
   .flag_c (flag_c),
   .flag_z (flag_z)
);

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;
   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic [4:0]  fn;
   logic [31:0] result;
   logic        flag_n, flag_v, flag_c, flag_z;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;

   always #2 clk = ~clk;

   alu_core i_alu_core (
      .a(a), .b(b), .fn(fn), .result(result),
      .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z)
   );

   function automatic logic [4:0] mk(input logic s, input logic [1:0] sel,
                                     input logic sh, input logic m);
      return {s, sel, sh, m};
   endfunction

   task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [4:0] f);
      @(posedge clk);
      a = av; b = bv; fn = f;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h fn=%b)", req, act, exp, a, b, fn);
      end
   endtask

   task automatic t_idle();
      apply(32'h0, 32'h0, 5'b00000);
      check("R7 idle result", result, 32'h0);
      check("R7 idle zero flag", {31'b0, flag_z}, 32'h1);
   endtask

   task automatic t_add();
      logic [31:0] av [4] = '{32'd5, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h12345678};
      logic [31:0] bv [4] = '{32'd7, 32'h1, 32'h1, 32'h0FEDCBA9};
      for (int i = 0; i < 4; i++) begin
         logic [32:0] w;
         logic [31:0] s;
         w = {1'b0, av[i]} + {1'b0, bv[i]};
         s = w[31:0];
         apply(av[i], bv[i], mk(1'b0, 2'b00, 1'b0, 1'b1));
         check("R1 add", result, s);
         check("R8 add carry", {31'b0, flag_c}, {31'b0, w[32]});
         check("R8 add neg", {31'b0, flag_n}, {31'b0, s[31]});
         check("R8 add ovf", {31'b0, flag_v},
               {31'b0, (av[i][31] == bv[i][31]) && (s[31] != av[i][31])});
         check("R7 add zero", {31'b0, flag_z}, {31'b0, s == 0});
      end
   endtask

   task automatic t_sub();
      logic [31:0] av [4] = '{32'd10, 32'd3, 32'h80000000, 32'hCAFE0000};
      logic [31:0] bv [4] = '{32'd3, 32'd10, 32'h1, 32'hCAFE0000};
      for (int i = 0; i < 4; i++) begin
         logic [31:0] s;
         s = av[i] - bv[i];
         apply(av[i], bv[i], mk(1'b1, 2'b00, 1'b0, 1'b1));
         check("R2 sub", result, s);
         check("R8 sub carry", {31'b0, flag_c}, {31'b0, av[i] >= bv[i]});
         check("R8 sub ovf", {31'b0, flag_v},
               {31'b0, (av[i][31] != bv[i][31]) && (s[31] != av[i][31])});
         check("R7 sub zero", {31'b0, flag_z}, {31'b0, av[i] == bv[i]});
      end
   endtask

   task automatic t_logic();
      logic [31:0] av = 32'hF0F0_1234;
      logic [31:0] bv = 32'h0FF0_FF00;
      for (int s = 0; s < 2; s++) begin
         apply(av, bv, mk(s[0], 2'b00, 1'b0, 1'b0)); check("R3 and", result, av & bv);
         apply(av, bv, mk(s[0], 2'b01, 1'b0, 1'b0)); check("R3 or",  result, av | bv);
         apply(av, bv, mk(s[0], 2'b10, 1'b0, 1'b0)); check("R3 xor", result, av ^ bv);
         apply(av, bv, mk(s[0], 2'b11, 1'b0, 1'b0)); check("R3 nor", result, ~(av | bv));
      end
      apply(32'hFFFF0000, 32'h0000FFFF, mk(1'b0, 2'b00, 1'b0, 1'b0));
      check("R7 and zero flag", {31'b0, flag_z}, 32'h1);
   endtask

   task automatic t_shift();
      apply(32'd4, 32'h1, mk(1'b0, 2'b00, 1'b1, 1'b0));
      check("R4 sll", result, 32'h10);
      apply(32'hFFFFFFE4, 32'h1, mk(1'b0, 2'b00, 1'b1, 1'b0));
      check("R4 sll upper A ignored", result, 32'h10);
      apply(32'd8, 32'h00AB_CDEF, mk(1'b0, 2'b01, 1'b1, 1'b0));
      check("R4 sel01 left", result, 32'hABCD_EF00);
      apply(32'd31, 32'h80000000, mk(1'b0, 2'b10, 1'b1, 1'b0));
      check("R4 srl", result, 32'h1);
      apply(32'd4, 32'h8000_00F0, mk(1'b0, 2'b11, 1'b1, 1'b0));
      check("R4 sra", result, 32'hF800_000F);
      apply(32'd31, 32'h80000000, mk(1'b0, 2'b11, 1'b1, 1'b0));
      check("R9 sra by 31", result, 32'hFFFFFFFF);
      apply(32'd31, 32'h7FFFFFFF, mk(1'b0, 2'b11, 1'b1, 1'b0));
      check("R9 sra by 31 positive", result, 32'h0);
      check("R7 shift zero flag", {31'b0, flag_z}, 32'h1);
      for (int m = 0; m < 4; m++) begin
         apply(32'hFFFFFFE0, 32'h9ABC_DEF1, mk(1'b0, m[1:0], 1'b1, 1'b0));
         check("R9 shift by zero", result, 32'h9ABC_DEF1);
      end
   endtask

   task automatic t_cmp();
      logic [31:0] av [5] = '{32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'd5, 32'd9};
      logic [31:0] bv [5] = '{32'h1, 32'h1, 32'hFFFFFFFF, 32'd5, 32'd2};
      for (int i = 0; i < 5; i++) begin
         for (int s = 0; s < 2; s++) begin
            logic [31:0] es, eu;
            es = {31'b0, $signed(av[i]) < $signed(bv[i])};
            eu = {31'b0, av[i] < bv[i]};
            apply(av[i], bv[i], mk(s[0], 2'b00, 1'b1, 1'b1));
            check("R5 signed less-than", result, es);
            check("R7 cmp zero flag", {31'b0, flag_z}, {31'b0, es == 0});
            apply(av[i], bv[i], mk(s[0], 2'b01, 1'b1, 1'b1));
            check("R6 unsigned less-than", result, eu);
         end
      end
   endtask

   initial begin
      a = '0; b = '0; fn = '0;
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_shift();
      t_cmp();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule